// File: doc/BRIEF.md
# Dual-channel PWM generator

This block drives two independent PWM outputs from a small 32-bit register interface. Each channel chooses one of four tick sources, thins that source with a 7-bit prescaler, and then toggles between a high phase and a low phase. The length of each phase is its own 16-bit count of prescaled ticks, so duty and period are set together as one word holding a high count and a low count. The tick sources are single-cycle enable pulses in the system clock domain; the block makes no clocks of its own.

Per-channel enables, clock gates, source selects and prescalers share one control word. Software inverts a channel by swapping its high and low counts, since the outputs carry no polarity control. A channel restarts in its high phase whenever it is switched on, and it stops low the moment it is switched off. Counts and prescaler values written while a channel runs are held back until the current period ends, so no period is ever torn.

Top module: `dpwm_gen`

## Requirements
- R1: Byte offset 0x0 holds channel 0's count word and 0x4 holds channel 1's. Bits 31:16 of a count word are the high count and bits 15:0 the low count. Offset 0xC reads as zero and ignores writes. Each read returns its data on `rdata_o` one cycle after `rd_en_i`, and every field reads back as written.
- R2: Offset 0x8 is the control word. Bit 0 and bit 1 enable channels 0 and 1. Bits 5:4 and 7:6 select their tick sources. Bits 14:8 and 22:16 hold their prescalers. Bits 15 and 23 are their clock gates. Bits 3:2 and 31:24 read as zero.
- R3: A prescaler value N passes one tick in every N+1 ticks of the selected source (select value k picks `tick_i[k]`). N = 0 passes every source tick.
- R4: A running channel holds its output high for the high count of prescaled ticks, then low for the low count, and repeats. The output changes only on a prescaled tick, on a restart, or on a stop.
- R5: A low count of zero still gives one low prescaled tick per period.
- R6: A channel's output stays low unless both its enable bit and its clock gate bit are set.
- R7: Clearing the enable bit drives the output low in the cycle right after the write, mid-period or not.
- R8: Enabling a channel restarts it in the high phase with a fresh prescaler. The output rises one cycle after the enabling write takes effect.
- R9: A high count of zero skips the high phase, so the output stays low.
- R10: Count and prescaler values written while a channel runs take effect at the next period boundary. The period in progress completes with the old values.
- R11: After reset every register reads zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| tick_i | input | 4 | Single-cycle enable ticks of the four sources |
| pwm_o | output | 2 | PWM outputs, bit 0 for channel 0 |

## Verification
On every cycle the assertions check several properties. A stopped or ungated channel stays low. An output edge always follows a prescaled tick, a restart or a stop. A restart with a zero high count stays low. Reads of the control word show the unused bits as zero. Only the bench's scenarios can show the rest, because it measures time rather than following individual edges: the exact phase lengths for each source and prescaler, the one-tick low phase, when a new setting takes effect at the period boundary, and the one-cycle restart latency.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int DIV_W   = 7;
  localparam int CNT_W   = 16;
  localparam int DATA_W  = 32;

  // control word layout; software depends on these positions
  localparam int EN_LSB   = 0;
  localparam int SEL_LSB  = 4;
  localparam int DIV_LSB  = 8;
  localparam int CH_STEP  = 8;   // prescaler/gate stride between channels
  localparam int GATE_OFS = 7;   // gate sits right above the prescaler

  localparam int CTRL_IDX = NUM_CH;  // word index of the control register

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } ch_cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } ch_cnt_t;

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[EN_LSB + c] = 1'b1;
      m[SEL_LSB + SEL_W*c +: SEL_W] = '1;
      m[DIV_LSB + CH_STEP*c +: DIV_W] = '1;
      m[DIV_LSB + CH_STEP*c + GATE_OFS] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ch_cfg_t           cfg_o [NUM_CH],
  output ch_cnt_t           cnt_o [NUM_CH]
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] CMASK = ctrl_mask();

  logic [IDX_W-1:0]  idx;
  logic [1:0]        unused_addr_lsb;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt_q [NUM_CH];
  logic [DATA_W-1:0] rdata_d;

  assign idx             = addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && idx == IDX_W'(CTRL_IDX)) begin
      ctrl_q <= wdata_i & CMASK;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[c] <= '0;
      end else if (wr_en_i && idx == IDX_W'(c)) begin
        cnt_q[c] <= wdata_i;
      end
    end

    assign cnt_o[c].hi   = cnt_q[c][DATA_W-1 -: CNT_W];
    assign cnt_o[c].lo   = cnt_q[c][CNT_W-1:0];
    assign cfg_o[c].en   = ctrl_q[EN_LSB + c];
    assign cfg_o[c].sel  = ctrl_q[SEL_LSB + SEL_W*c +: SEL_W];
    assign cfg_o[c].div  = ctrl_q[DIV_LSB + CH_STEP*c +: DIV_W];
    assign cfg_o[c].gate = ctrl_q[DIV_LSB + CH_STEP*c + GATE_OFS];
  end

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == IDX_W'(c)) rdata_d = cnt_q[c];
    end
    if (idx == IDX_W'(CTRL_IDX)) rdata_d = ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // >= keeps the divider safe if a smaller value lands mid-count
  assign wrap   = cnt_q >= div_i;
  assign tick_o = run_i && tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dpwm_phase.sv
module dpwm_phase #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ptick_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pwm_o,
  output logic             active_o,
  output logic             load_o,
  output logic [DIV_W-1:0] div_o
);
  logic             active_q;
  logic             hi_ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hi_s_q;
  logic [CNT_W-1:0] lo_s_q;
  logic [DIV_W-1:0] div_s_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   lo_eff;
  logic             hi_done;
  logic             lo_done;

  assign load_o   = run_i && !active_q;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  // a zero low count still costs one tick
  assign lo_eff   = (lo_s_q == '0) ? (CNT_W+1)'(1) : {1'b0, lo_s_q};
  assign hi_done  = cnt_inc >= {1'b0, hi_s_q};
  assign lo_done  = cnt_inc >= lo_eff;
  assign pwm_o    = active_q && run_i && hi_ph_q;
  assign active_o = active_q;
  assign div_o    = div_s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_ph_q  <= 1'b0;
      cnt_q    <= '0;
      hi_s_q   <= '0;
      lo_s_q   <= '0;
      div_s_q  <= '0;
    end else if (!run_i) begin
      active_q <= 1'b0;
      hi_ph_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      hi_s_q   <= hi_i;
      lo_s_q   <= lo_i;
      div_s_q  <= div_i;
      hi_ph_q  <= hi_i != '0;
      cnt_q    <= '0;
    end else if (ptick_i) begin
      if (hi_ph_q) begin
        if (hi_done) begin
          hi_ph_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end else if (lo_done) begin
        // period boundary: pick up the latest settings
        hi_s_q  <= hi_i;
        lo_s_q  <= lo_i;
        div_s_q <= div_i;
        hi_ph_q <= hi_i != '0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
  import dpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic [NUM_CH-1:0] pwm_o
);
  ch_cfg_t           cfg [NUM_CH];
  ch_cnt_t           cnt [NUM_CH];
  logic [NUM_CH-1:0] ch_run;
  logic [NUM_CH-1:0] ch_ptick;
  logic [NUM_CH-1:0] ch_load;
  logic [NUM_CH-1:0] ch_active;
  logic [NUM_CH-1:0] ch_hi_zero;

  dpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg),
    .cnt_o   (cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             src_tick;
    logic [DIV_W-1:0] div_s;

    assign ch_run[c]     = cfg[c].en && cfg[c].gate;
    assign src_tick      = tick_i[cfg[c].sel];
    assign ch_hi_zero[c] = cnt[c].hi == '0;

    dpwm_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ch_run[c] && ch_active[c]),
      .tick_i (src_tick),
      .div_i  (div_s),
      .tick_o (ch_ptick[c])
    );

    dpwm_phase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (ch_run[c]),
      .ptick_i  (ch_ptick[c]),
      .hi_i     (cnt[c].hi),
      .lo_i     (cnt[c].lo),
      .div_i    (cfg[c].div),
      .pwm_o    (pwm_o[c]),
      .active_o (ch_active[c]),
      .load_o   (ch_load[c]),
      .div_o    (div_s)
    );
  end
endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk
  import dpwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] ch_ptick,
  input logic [NUM_CH-1:0] ch_load,
  input logic [NUM_CH-1:0] ch_hi_zero
);
  // R2
  ctrl_unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[ADDR_W-1:2] == (ADDR_W-2)'(CTRL_IDX))
    |=> (rdata_o[31:24] == '0 && rdata_o[3:2] == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    stopped_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_run[c] |-> !pwm_o[c]);

    // R4
    edge_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pwm_o[c]) |-> ($past(ch_ptick[c]) || $past(ch_load[c]) || !ch_run[c]));

    // R9
    hi_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_load[c] && ch_hi_zero[c]) |=> !pwm_o[c]);
  end
endmodule

bind dpwm_gen dpwm_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .pwm_o      (pwm_o),
  .ch_run     (ch_run),
  .ch_ptick   (ch_ptick),
  .ch_load    (ch_load),
  .ch_hi_zero (ch_hi_zero)
);

// File: tb/dpwm_gen_bench.sv
`timescale 1ns/1ps
module dpwm_gen_bench;
  localparam int ADDR_W = 4;
  localparam int NV = 8;
  localparam int SRC_PER [4] = '{1, 2, 3, 4};
  // vectors: source select, prescaler, high count, low count
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int V_DIV [NV] = '{0, 0, 1, 2, 3, 1, 0, 0};
  localparam int V_HI  [NV] = '{3, 2, 2, 1, 5, 4, 1, 6};
  localparam int V_LO  [NV] = '{2, 4, 3, 1, 1, 0, 6, 3};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [3:0]        tick = '0;
  logic [1:0]        pwm;
  logic [31:0]       ctrl_img = '0;
  int                tests = 0;
  int                fails = 0;
  int                cyc = 0;

  always #2.5 clk = ~clk;

  dpwm_gen #(.ADDR_W(ADDR_W)) u_dpwm_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .tick_i  (tick),
    .pwm_o   (pwm)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int k = 0; k < 4; k++) tick[k] <= (cyc % SRC_PER[k]) == 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_now(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  function automatic logic [31:0] set_ch(input logic [31:0] img, input int ch, input bit en,
                                         input bit gate, input int sel, input int div);
    logic [31:0] r;
    r = img;
    r[ch] = en;
    r[4 + 2*ch +: 2] = 2'(sel);
    r[8 + 8*ch +: 7] = 7'(div);
    r[15 + 8*ch] = gate;
    return r;
  endfunction

  task automatic count_level(input int ch, input bit lvl, output int n);
    n = 0;
    while (pwm[ch] == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise(input int ch);
    int g = 0;
    while (pwm[ch] == 1'b1 && g < 5000) begin g++; @(negedge clk); end
    while (pwm[ch] == 1'b0 && g < 5000) begin g++; @(negedge clk); end
  endtask

  task automatic high_cycles(input int ch, input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm[ch]) n++;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h1, l1, h2, l2, n, per, dv, lo_e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(0, d); chk("R11 count0 after reset", d, 0);
    rd(4, d); chk("R11 count1 after reset", d, 0);
    rd(8, d); chk("R11 ctrl after reset", d, 0);
    chk("R11 outputs after reset", int'(pwm), 0);

    // R1 readback and unused word
    wr(0, 32'hABCD_1234); rd(0, d); chk("R1 count0 readback", d, 32'hABCD_1234);
    wr(4, 32'h0001_FFFF); rd(4, d); chk("R1 count1 readback", d, 32'h0001_FFFF);
    wr(12, 32'hFFFF_FFFF); rd(12, d); chk("R1 unused word reads zero", d, 0);
    // R2 control field mask
    wr(8, 32'hFFFF_FFFF); rd(8, d); chk("R2 ctrl implemented bits", d, 32'h00FF_FFF3);
    wr(8, 32'h0); ctrl_img = '0;

    // table walk: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int ch = v % 2;
      ctrl_img = set_ch(ctrl_img, ch, 1'b0, 1'b0, 0, 0);
      wr(8, ctrl_img);
      wr(4*ch, {16'(V_HI[v]), 16'(V_LO[v])});
      ctrl_img = set_ch(ctrl_img, ch, 1'b1, 1'b1, V_SEL[v], V_DIV[v]);
      wr(8, ctrl_img);
      wait_rise(ch);
      count_level(ch, 1'b1, h1);
      count_level(ch, 1'b0, l1);
      count_level(ch, 1'b1, h2);
      count_level(ch, 1'b0, l2);
      per  = SRC_PER[V_SEL[v]];
      dv   = V_DIV[v] + 1;
      lo_e = (V_LO[v] == 0) ? 1 : V_LO[v];
      chk($sformatf("R3 R4 vec%0d high length", v), h2, V_HI[v] * dv * per);
      if (V_LO[v] == 0)
        chk($sformatf("R5 vec%0d one-tick low", v), l2, lo_e * dv * per);
      else
        chk($sformatf("R3 R4 vec%0d low length", v), l2, lo_e * dv * per);
    end
    ctrl_img = '0; wr(8, ctrl_img);

    // R8 restart in high phase one cycle after enable
    wr(0, {16'd40, 16'd40});
    ctrl_img = set_ch(ctrl_img, 0, 1'b1, 1'b1, 0, 0);
    wr(8, ctrl_img);
    chk("R8 low in write-commit cycle", int'(pwm[0]), 0);
    @(negedge clk);
    chk("R8 high one cycle later", int'(pwm[0]), 1);

    // R7 immediate stop mid-high
    @(negedge clk);
    chk("R7 still high before stop", int'(pwm[0]), 1);
    ctrl_img = set_ch(ctrl_img, 0, 1'b0, 1'b1, 0, 0);
    wr_now(8, ctrl_img);
    chk("R7 low right after stop", int'(pwm[0]), 0);
    high_cycles(0, 30, n); chk("R7 stays low", n, 0);

    // R6 gate clear blocks output, enable clear blocks output
    wr(0, {16'd2, 16'd2});
    ctrl_img = set_ch(ctrl_img, 0, 1'b1, 1'b0, 0, 0);
    wr(8, ctrl_img);
    high_cycles(0, 60, n); chk("R6 gate off keeps low", n, 0);
    ctrl_img = set_ch(ctrl_img, 0, 1'b0, 1'b1, 0, 0);
    wr(8, ctrl_img);
    high_cycles(0, 60, n); chk("R6 enable off keeps low", n, 0);

    // R9 zero high count
    wr(4, {16'd0, 16'd3});
    ctrl_img = set_ch(ctrl_img, 1, 1'b1, 1'b1, 1, 0);
    wr(8, ctrl_img);
    high_cycles(1, 80, n); chk("R9 zero high count stays low", n, 0);
    ctrl_img = set_ch(ctrl_img, 1, 1'b0, 1'b0, 0, 0);
    wr(8, ctrl_img);

    // R10 new counts wait for the period boundary
    wr(0, {16'd4, 16'd4});
    ctrl_img = set_ch(ctrl_img, 0, 1'b1, 1'b1, 0, 0);
    wr(8, ctrl_img);
    wait_rise(0);
    wait_rise(0);
    wr_now(0, {16'd2, 16'd6});
    count_level(0, 1'b1, h1); h1 = h1 + 1;
    count_level(0, 1'b0, l1);
    count_level(0, 1'b1, h2);
    count_level(0, 1'b0, l2);
    chk("R10 current high kept", h1, 4);
    chk("R10 current low kept", l1, 4);
    chk("R10 next high updated", h2, 2);
    chk("R10 next low updated", l2, 6);

    // R10 prescaler change waits for the boundary as well
    ctrl_img = set_ch(ctrl_img, 0, 1'b1, 1'b1, 0, 1);
    wait_rise(0);
    wr_now(8, ctrl_img);
    count_level(0, 1'b1, h1); h1 = h1 + 1;
    count_level(0, 1'b0, l1);
    count_level(0, 1'b1, h2);
    chk("R10 old prescaler high", h1, 2);
    chk("R10 old prescaler low", l1, 6);
    chk("R10 new prescaler high", h2, 4);

    summary();
    $finish;
  end
endmodule